// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Frame Status Flags

This block takes one serial input line and rebuilds character frames from it. It is driven by a tick that pulses sixteen times per bit period. Each bit is judged by three samples taken near the middle of the bit, and the majority of the three gives the bit value. A completed frame is written into a nine-bit receive word. A set of status flags goes with that word: full, overrun, noise, framing error, parity error and idle line. The character can have eight or nine data bits, sent least significant bit first. An optional parity bit follows the data, and one stop bit ends the frame.

The receive word is the block's output stream. `rx_full` acts as the valid signal. A consumer takes the word by pulsing `status_rd` and then `data_rd`; this pair acts as the ready handshake and releases the word. The serial side cannot be stalled. A frame that completes while the word is still held is lost, and it raises the overrun flag. The flags and the configuration inputs are plain levels. The configuration may only change while no frame is being received. `rx_line` must already be synchronous to `clk`.

Top module: `uart_rx_status`

## Requirements
- R1: A frame is a 0 start bit, then 8 data bits (9 when `cfg_nine_bit`=1) sent LSB first, then a parity bit when `cfg_par_en`=1, then one stop bit. The data bits appear on `rx_data` with the first data bit on bit 0. In 8-bit mode `rx_data[8]` reads 0.
- R2: The tick on which the receiver first sees `rx_line`=0 while it is hunting is tick 0 of the start bit. Every bit lasts 16 ticks. The receiver samples ticks 7, 8 and 9 of each bit, and the majority of these three samples is the bit value. Ticks outside 7..9 have no effect on the value or on the noise flag.
- R3: A start bit whose majority is 1 is a false start. The receiver then goes back to hunting. No data is loaded and no flag changes.
- R4: `rx_noise` is set when the three samples of the start bit, of any data or parity bit, or of the stop bit do not all agree.
- R5: `rx_frame_err` is set when the majority of the stop bit is 0. A frame that is 0 throughout, stop bit included, is still loaded, with data 0 and `rx_frame_err`=1.
- R6: With `cfg_par_en`=1, `rx_par_err` is set when the count of ones over the data bits and the parity bit is odd and `cfg_par_odd`=0, or is even and `cfg_par_odd`=1.
- R7: The noise, framing and parity flags change only in the cycle in which `rx_full` is set. That cycle follows the tick 9 of the stop bit.
- R8: A frame that completes while `rx_full`=1 sets `rx_overrun` and is discarded. `rx_data` keeps the earlier word.
- R9: While `rx_overrun`=1, every completing frame is discarded. After the flags are cleared, the next frame is loaded.
- R10: A `data_rd` pulse that follows a `status_rd` pulse clears `rx_full`, `rx_overrun`, `rx_noise`, `rx_frame_err`, `rx_par_err` and `rx_idle` together. A `data_rd` pulse with no `status_rd` before it changes nothing.
- R11: `rx_idle` is set after a run of consecutive ticks with `rx_line`=1. The run is 160 ticks, or 176 when `cfg_nine_bit`=1. With `cfg_idle_after_stop`=0, every high tick counts. With `cfg_idle_after_stop`=1, only high ticks after the stop bit's tick 9 count.
- R12: After `rx_idle` has been set, it cannot be set again until a later frame has been loaded and has set `rx_full`. A loaded all-zero frame counts as such a frame.
- R13: While `cfg_wakeup`=1, `rx_idle` is held at 0.
- R14: When a frame completes in the same cycle as the clearing `data_rd`, the new frame is loaded, `rx_full` stays 1 and `rx_overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial input, synchronous to clk, idles high |
| baud_tick16 | input | 1 | One-cycle pulse, 16 per bit period |
| cfg_nine_bit | input | 1 | 1 = nine data bits |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_idle_after_stop | input | 1 | 1 = idle count starts after the stop bit |
| cfg_wakeup | input | 1 | 1 = idle flag held low |
| status_rd | input | 1 | Status read pulse, arms the clear |
| data_rd | input | 1 | Data read pulse, clears when armed |
| rx_data | output | 9 | Received word |
| rx_full | output | 1 | Word held (valid) |
| rx_overrun | output | 1 | Frame lost while full |
| rx_noise | output | 1 | Samples disagreed within the frame |
| rx_frame_err | output | 1 | Stop bit read as 0 |
| rx_par_err | output | 1 | Parity mismatch |
| rx_idle | output | 1 | Idle line detected |

## Verification
The two events that can land in the same cycle are the commit of a completed frame and the clear from the read pair. The bench arms the clear with `status_rd`. It then sends a second frame and pulses `data_rd` on exactly the tick that carries the stop bit's tick 9. A correct design shows the second word with `rx_full` set and `rx_overrun` clear. A design that lets the old full state win shows the first word or a set overrun flag.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic noise;
    logic framing;
    logic parity;
  } rx_err_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic active,
  output logic start_seen,
  output logic bit_done,
  output logic bit_val,
  output logic bit_noisy
);
  import uart_rx_pkg::*;

  localparam int PW = $clog2(OVS);
  localparam int MID = OVS / 2;
  localparam logic [PW-1:0] PH_A    = PW'(MID - 1);
  localparam logic [PW-1:0] PH_B    = PW'(MID);
  localparam logic [PW-1:0] PH_C    = PW'(MID + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);

  logic [PW-1:0] ph;
  logic smp_a, smp_b;

  assign start_seen = tick && !active && !rx;
  assign bit_done   = tick && active && (ph == PH_C);
  assign bit_val    = maj3(smp_a, smp_b, rx);
  assign bit_noisy  = (smp_a != smp_b) || (smp_b != rx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= '0;
      smp_a <= 1'b1;
      smp_b <= 1'b1;
    end else if (start_seen) begin
      ph <= PW'(1);
    end else if (tick && active) begin
      if (ph == PH_A) smp_a <= rx;
      if (ph == PH_B) smp_b <= rx;
      ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
    end
  end

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer #(
  parameter int BASE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_seen,
  input  logic                      bit_done,
  input  logic                      bit_val,
  input  logic                      bit_noisy,
  input  logic                      cfg_nine,
  input  logic                      cfg_par_en,
  input  logic                      cfg_par_odd,
  output logic                      active,
  output logic                      frame_done,
  output logic [BASE_W:0]           frame_data,
  output uart_rx_pkg::rx_err_t      frame_err
);
  import uart_rx_pkg::*;

  localparam int IW = $clog2(BASE_W + 4);

  logic [IW-1:0]   idx;
  logic [IW-1:0]   n_data;
  logic [IW-1:0]   stop_idx;
  logic [BASE_W:0] data_q;
  logic            par_acc, noise_acc;
  logic            is_start, is_data, is_stop;

  assign n_data   = IW'(BASE_W) + IW'(cfg_nine);
  assign stop_idx = n_data + IW'(1) + IW'(cfg_par_en);
  assign is_start = (idx == '0);
  assign is_data  = !is_start && (idx <= n_data);
  assign is_stop  = (idx == stop_idx);

  assign frame_done        = bit_done && active && is_stop;
  assign frame_data        = data_q;
  assign frame_err.noise   = noise_acc | bit_noisy;
  assign frame_err.framing = !bit_val;
  assign frame_err.parity  = cfg_par_en & (par_acc ^ cfg_par_odd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      idx       <= '0;
      data_q    <= '0;
      par_acc   <= 1'b0;
      noise_acc <= 1'b0;
    end else if (start_seen) begin
      active    <= 1'b1;
      idx       <= '0;
      data_q    <= '0;
      par_acc   <= 1'b0;
      noise_acc <= 1'b0;
    end else if (bit_done) begin
      if (is_start) begin
        if (bit_val) begin
          active <= 1'b0;
        end else begin
          noise_acc <= bit_noisy;
          idx       <= IW'(1);
        end
      end else if (is_stop) begin
        active <= 1'b0;
      end else begin
        for (int i = 0; i <= BASE_W; i++) begin
          if (is_data && (idx == IW'(i + 1))) data_q[i] <= bit_val;
        end
        par_acc   <= par_acc ^ bit_val;
        noise_acc <= noise_acc | bit_noisy;
        idx       <= idx + 1'b1;
      end
    end
  end

  assert_false_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_done && is_start && bit_val && !start_seen) |=> !active);

  assert_frame_ends_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !active);

endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
  parameter int OVS    = 16,
  parameter int BASE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic active,
  input  logic cfg_nine,
  input  logic cfg_after_stop,
  output logic idle_hit
);
  localparam int SHORT_T = (BASE_W + 2) * OVS;
  localparam int LONG_T  = (BASE_W + 3) * OVS;
  localparam int CW      = $clog2(LONG_T + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] thr;
  logic          blocked;

  assign thr      = cfg_nine ? CW'(LONG_T) : CW'(SHORT_T);
  assign blocked  = cfg_after_stop && active;
  assign idle_hit = tick && rx && !blocked && (cnt == thr - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      if (!rx || blocked) cnt <= '0;
      else if (cnt < thr) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int OVS    = 16,
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              baud_tick16,
  input  logic              cfg_nine_bit,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_idle_after_stop,
  input  logic              cfg_wakeup,
  input  logic              status_rd,
  input  logic              data_rd,
  output logic [BASE_W:0]   rx_data,
  output logic              rx_full,
  output logic              rx_overrun,
  output logic              rx_noise,
  output logic              rx_frame_err,
  output logic              rx_par_err,
  output logic              rx_idle
);
  import uart_rx_pkg::*;

  logic            start_seen, bit_done, bit_val, bit_noisy;
  logic            active, frame_done, idle_hit;
  logic [BASE_W:0] frame_data;
  rx_err_t         frame_err;

  logic            clr_arm_q, idle_arm_q, clear;

  uart_rx_sampler #(.OVS(OVS)) sampler_i (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick16), .rx(rx_line), .active(active),
    .start_seen(start_seen), .bit_done(bit_done), .bit_val(bit_val), .bit_noisy(bit_noisy)
  );

  uart_rx_framer #(.BASE_W(BASE_W)) framer_i (
    .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .bit_done(bit_done),
    .bit_val(bit_val), .bit_noisy(bit_noisy), .cfg_nine(cfg_nine_bit),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .active(active),
    .frame_done(frame_done), .frame_data(frame_data), .frame_err(frame_err)
  );

  uart_rx_idle #(.OVS(OVS), .BASE_W(BASE_W)) idle_i (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick16), .rx(rx_line), .active(active),
    .cfg_nine(cfg_nine_bit), .cfg_after_stop(cfg_idle_after_stop), .idle_hit(idle_hit)
  );

  assign clear = data_rd && clr_arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_arm_q    <= 1'b0;
      idle_arm_q   <= 1'b1;
      rx_data      <= '0;
      rx_full      <= 1'b0;
      rx_overrun   <= 1'b0;
      rx_noise     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_par_err   <= 1'b0;
      rx_idle      <= 1'b0;
    end else begin
      if (status_rd)    clr_arm_q <= 1'b1;
      else if (data_rd) clr_arm_q <= 1'b0;

      if (clear) begin
        rx_full      <= 1'b0;
        rx_overrun   <= 1'b0;
        rx_noise     <= 1'b0;
        rx_frame_err <= 1'b0;
        rx_par_err   <= 1'b0;
        rx_idle      <= 1'b0;
      end

      if (frame_done) begin
        if (rx_full && !clear) begin
          rx_overrun <= 1'b1;
        end else begin
          rx_data      <= frame_data;
          rx_full      <= 1'b1;
          rx_noise     <= frame_err.noise;
          rx_frame_err <= frame_err.framing;
          rx_par_err   <= frame_err.parity;
          idle_arm_q   <= 1'b1;
        end
      end

      if (cfg_wakeup) begin
        rx_idle <= 1'b0;
      end else if (idle_hit && idle_arm_q) begin
        rx_idle    <= 1'b1;
        idle_arm_q <= 1'b0;
      end
    end
  end

  assert_overrun_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_full);

  assert_data_held_in_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !clear) |=> $stable(rx_data));

  assert_top_bit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_full) && !cfg_nine_bit) |-> !rx_data[BASE_W]);

  assert_flags_with_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_noise || rx_frame_err || rx_par_err) |-> rx_full);

  assert_wakeup_holds_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wakeup |=> !rx_idle);

  assert_idle_needs_rearm_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_idle) |-> $past(idle_arm_q));

endmodule

// File: tb/uart_rx_status_tb_top.sv
module uart_rx_status_tb_top;
  localparam int OVS   = 16;
  localparam int STOPB = 50;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, rx_line = 1'b1, tick = 1'b0;
  logic       cfg_nine = 1'b0, cfg_pe = 1'b0, cfg_odd = 1'b0, cfg_after = 1'b0, cfg_wake = 1'b0;
  logic       status_rd = 1'b0, data_rd = 1'b0;
  logic [8:0] rx_data;
  logic       rx_full, rx_overrun, rx_noise, rx_frame_err, rx_par_err, rx_idle;

  int errors = 0;
  int checks = 0;

  uart_rx_status dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick16(tick),
    .cfg_nine_bit(cfg_nine), .cfg_par_en(cfg_pe), .cfg_par_odd(cfg_odd),
    .cfg_idle_after_stop(cfg_after), .cfg_wakeup(cfg_wake),
    .status_rd(status_rd), .data_rd(data_rd), .rx_data(rx_data), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err),
    .rx_par_err(rx_par_err), .rx_idle(rx_idle)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tk(input logic v, input logic rd);
    @(negedge clk);
    rx_line = v; tick = 1'b1; data_rd = rd;
    @(negedge clk);
    tick = 1'b0; data_rd = 1'b0;
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) tk(1'b1, 1'b0);
  endtask

  task automatic send_bit(input logic v, input int gph, input logic rd9);
    for (int k = 0; k < OVS; k++) tk((k == gph) ? ~v : v, rd9 && (k == 9));
  endtask

  task automatic send_head(input int d, input logic pflip, input int gbit, input int gph);
    int   nd;
    int   mask;
    logic p;
    nd   = cfg_nine ? 9 : 8;
    mask = (1 << nd) - 1;
    send_bit(1'b0, (gbit == 0) ? gph : -1, 1'b0);
    for (int i = 0; i < nd; i++) send_bit(logic'((d >> i) & 1), (gbit == i + 1) ? gph : -1, 1'b0);
    if (cfg_pe) begin
      p = (^(d & mask)) ^ cfg_odd ^ pflip;
      send_bit(p, (gbit == nd + 1) ? gph : -1, 1'b0);
    end
  endtask

  task automatic send_frame(input int d, input logic pflip, input logic stopv,
                            input int gbit, input int gph, input logic rd_stop);
    send_head(d, pflip, gbit, gph);
    send_bit(stopv, (gbit == STOPB) ? gph : -1, rd_stop);
  endtask

  task automatic arm_status;
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic do_clear;
    arm_status();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset full", rx_full, 0);
    chk("R10 reset overrun", rx_overrun, 0);
    chk("R7 reset error flags", {rx_noise, rx_frame_err, rx_par_err}, 0);
    chk("R11 reset idle", rx_idle, 0);

    // R11: short idle count from reset, 8-bit
    idle_ticks(159);
    chk("R11 idle before 160 ticks", rx_idle, 0);
    idle_ticks(1);
    chk("R11 idle at 160 ticks", rx_idle, 1);
    do_clear();
    chk("R10 clear drops idle", rx_idle, 0);
    idle_ticks(200);
    chk("R12 idle not rearmed without frame", rx_idle, 0);

    // R12/R11: frame rearms; stop bit's 16 high ticks count in short mode
    send_frame(0, 1'b0, 1'b1, -1, -1, 1'b0);
    chk("R12 frame loaded", rx_full, 1);
    idle_ticks(143);
    chk("R11 short idle 159 ticks", rx_idle, 0);
    idle_ticks(1);
    chk("R12 idle rearmed by frame", rx_idle, 1);
    do_clear();

    // R11: long mode, counts after stop tick 9 (6 ticks) then 154 more
    cfg_after = 1'b1;
    send_frame(0, 1'b0, 1'b1, -1, -1, 1'b0);
    idle_ticks(153);
    chk("R11 long idle 159 ticks", rx_idle, 0);
    idle_ticks(1);
    chk("R11 long idle 160 ticks", rx_idle, 1);
    do_clear();

    // R12/R5: break frame rearms idle
    send_frame(0, 1'b0, 1'b0, -1, -1, 1'b0);
    chk("R5 break full", rx_full, 1);
    chk("R5 break framing", rx_frame_err, 1);
    chk("R5 break data", int'(rx_data), 0);
    idle_ticks(200);
    chk("R12 break rearms idle", rx_idle, 1);
    do_clear();
    cfg_after = 1'b0;

    // R11: nine-bit threshold 176
    cfg_nine = 1'b1;
    send_frame(0, 1'b0, 1'b1, -1, -1, 1'b0);
    idle_ticks(159);
    chk("R11 nine-bit idle 175 ticks", rx_idle, 0);
    idle_ticks(1);
    chk("R11 nine-bit idle 176 ticks", rx_idle, 1);
    do_clear();
    cfg_nine = 1'b0;

    // R13: wakeup holds idle low
    cfg_wake = 1'b1;
    send_frame(8'h21, 1'b0, 1'b1, -1, -1, 1'b0);
    idle_ticks(200);
    chk("R13 wakeup blocks idle", rx_idle, 0);
    cfg_wake = 1'b0;
    do_clear();

    // R3: false start
    for (int i = 0; i < 5; i++) tk(1'b0, 1'b0);
    idle_ticks(30);
    chk("R3 false start no load", rx_full, 0);
    chk("R3 false start no noise", rx_noise, 0);

    // R4/R2: noise
    send_frame(8'h5A, 1'b0, 1'b1, 4, 8, 1'b0);
    chk("R4 data-bit noise flag", rx_noise, 1);
    chk("R4 data-bit noise value", int'(rx_data), 8'h5A);
    do_clear();
    send_frame(8'hC3, 1'b0, 1'b1, 0, 7, 1'b0);
    chk("R4 start-bit noise flag", rx_noise, 1);
    chk("R4 start-bit noise value", int'(rx_data), 8'hC3);
    do_clear();
    send_frame(8'h0F, 1'b0, 1'b1, STOPB, 9, 1'b0);
    chk("R4 stop-bit noise flag", rx_noise, 1);
    chk("R5 noisy stop no framing", rx_frame_err, 0);
    do_clear();
    send_frame(8'h96, 1'b0, 1'b1, 3, 3, 1'b0);
    chk("R2 glitch at tick 3 ignored", rx_noise, 0);
    chk("R2 glitch at tick 3 value", int'(rx_data), 8'h96);
    do_clear();
    send_frame(8'h69, 1'b0, 1'b1, 6, 10, 1'b0);
    chk("R2 glitch at tick 10 ignored", rx_noise, 0);
    chk("R2 glitch at tick 10 value", int'(rx_data), 8'h69);
    do_clear();

    // R5: framing error with data
    send_frame(8'h3C, 1'b0, 1'b0, -1, -1, 1'b0);
    chk("R5 framing flag", rx_frame_err, 1);
    chk("R5 framing data kept", int'(rx_data), 8'h3C);
    idle_ticks(20);
    do_clear();

    // R7: flags commit exactly after stop tick 9
    cfg_pe = 1'b1;
    send_head(8'h71, 1'b1, -1, -1);
    for (int k = 0; k < 9; k++) tk(1'b1, 1'b0);
    chk("R7 full not before stop tick 9", rx_full, 0);
    chk("R7 parity not before stop tick 9", rx_par_err, 0);
    tk(1'b1, 1'b0);
    chk("R7 full after stop tick 9", rx_full, 1);
    chk("R7 parity with full", rx_par_err, 1);
    idle_ticks(6);
    do_clear();
    cfg_pe = 1'b0;

    // R8/R9/R10: overrun
    send_frame(8'h11, 1'b0, 1'b1, -1, -1, 1'b0);
    send_frame(8'h22, 1'b0, 1'b1, -1, -1, 1'b0);
    chk("R8 overrun set", rx_overrun, 1);
    chk("R8 old data kept", int'(rx_data), 8'h11);
    send_frame(8'h33, 1'b0, 1'b1, -1, -1, 1'b0);
    chk("R9 frame lost in overrun", int'(rx_data), 8'h11);
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    chk("R10 lone data read keeps full", rx_full, 1);
    chk("R10 lone data read keeps overrun", rx_overrun, 1);
    do_clear();
    chk("R10 clear full", rx_full, 0);
    chk("R10 clear overrun", rx_overrun, 0);
    send_frame(8'h44, 1'b0, 1'b1, -1, -1, 1'b0);
    chk("R9 load after clear", int'(rx_data), 8'h44);
    chk("R9 no overrun after clear", rx_overrun, 0);

    // R14: clear and completion in the same cycle
    arm_status();
    send_frame(8'h55, 1'b0, 1'b1, -1, -1, 1'b1);
    chk("R14 full stays", rx_full, 1);
    chk("R14 new data loaded", int'(rx_data), 8'h55);
    chk("R14 no overrun", rx_overrun, 0);
    do_clear();

    // R1/R6 sweep over formats
    for (int c = 0; c < 8; c++) begin
      cfg_nine = c[0]; cfg_pe = c[1]; cfg_odd = c[2];
      for (int k = 0; k < 10; k++) begin
        int mask;
        int d;
        mask = cfg_nine ? 9'h1FF : 8'hFF;
        d = (k == 0) ? 0 : (k == 1) ? mask : ((k * 83 + k * k * 29 + 1) & mask);
        for (int f = 0; f <= int'(cfg_pe); f++) begin
          send_frame(d, f[0], 1'b1, -1, -1, 1'b0);
          idle_ticks(3);
          chk("R1 sweep data", int'(rx_data), d);
          chk("R1 sweep full", rx_full, 1);
          chk("R6 sweep parity flag", rx_par_err, f);
          chk("R4 sweep clean noise", rx_noise, 0);
          chk("R5 sweep clean framing", rx_frame_err, 0);
          do_clear();
          chk("R10 sweep cleared", rx_full, 0);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule